// File: doc/BRIEF.md
# Inbound Hub Transaction Decoder

This block sorts each transaction that arrives on the downstream hub port into one of four outcomes. It can accept the transaction into main memory, forward it to the graphics port, answer it with a master-abort completion, or discard it without reply. Each request carries a kind (memory, I/O, configuration), a write flag, a flag that says whether the requester expects a completion, and an address of up to 64 bits.

The decode depends on the direction of the transfer. Above 4 GB, reads are aborted but writes are dropped. The graphics windows claim writes only, while the aperture claims both reads and writes. A small set of programmable registers, loaded through a select/data write port, defines the memory map. The registers hold the top of DRAM, the protected SMM window, two graphics base/limit windows, the aperture base and size, and the legacy-video forwarding enable.

The decision is registered. It appears one cycle after the request, as a two-bit code and a completion-request bit.

Top module: `hub_inbound_decoder`

## Requirements
- R1: dec_valid is high in the cycle after a cycle with req_valid high, and low in the cycle after a cycle with req_valid low. dec_code and dec_cpl keep their last value while no request arrives.
- R2: A request whose req_kind is not memory is never claimed. The kind codes are 0 memory, 1 I/O, 2 configuration and 3 reserved. Such a request gets code 2 (abort) when req_needs_cpl is 1, and code 3 (drop) otherwise. Decision codes: 0 accept to memory, 1 forward to graphics, 2 master abort, 3 drop.
- R3: A memory read with any address bit at or above bit 32 set gets code 2.
- R4: A memory write with any address bit at or above bit 32 set gets code 3.
- R5: A memory access inside the inclusive SMM window is refused. Reads get code 2 and writes get code 3. This rule beats the aperture, graphics, VGA and DRAM rules.
- R6: The aperture is enabled when its size exponent L satisfies AP_MIN_LOG2 <= L <= 31. An enabled aperture covers the 2^L-byte block that contains the aperture base. Reads and writes that hit it get code 0, and this rule beats the graphics windows. When L < AP_MIN_LOG2, the aperture matches nothing.
- R7: There are two graphics windows, each an inclusive base/limit pair; a window whose base exceeds its limit is empty. A write that hits either window gets code 1. A read that hits either window gets code 2.
- R8: The VGA range runs from 0xA0000 to 0xBFFFF. A write in this range gets code 1 only when the VGA enable bit is set. Any other access in this range falls through to the DRAM rule.
- R9: A memory access below 4 GB whose address is less than top-of-memory, and that no higher rule claims, gets code 0.
- R10: Memory reads below 4 GB that no rule claims get code 2. Memory writes below 4 GB that no rule claims get code 3.
- R11: dec_cpl is 1 for code 2 and 0 for code 3. For codes 0 and 1 it equals the request's req_needs_cpl.
- R12: The config port decodes cfg_sel as follows: 0 top-of-memory, 1 SMM base, 2 SMM limit, 3/4 window 0 base/limit, 5/6 window 1 base/limit, 7 aperture base, 8 aperture size exponent (cfg_wdata[4:0]), 9 VGA enable (cfg_wdata[0]). A register written in one cycle governs requests from the next cycle on, so a request in the same cycle sees the old value. After reset, top-of-memory is 0, every window is empty (base all ones, limit 0), the size exponent is 0 and VGA forwarding is off. The reset outputs are dec_valid 0, dec_code 3 and dec_cpl 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Config register write strobe |
| cfg_sel | input | 4 | Config register select |
| cfg_wdata | input | 32 | Config write data |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | Transaction kind |
| req_write | input | 1 | 1 for write, 0 for read |
| req_needs_cpl | input | 1 | Requester expects a completion |
| req_addr | input | ADDR_W | Transaction address |
| dec_valid | output | 1 | Decision present |
| dec_code | output | 2 | Decision code |
| dec_cpl | output | 1 | Completion packet to be returned |

## Verification
The assertions assume that the request fields are meaningful whenever req_valid is high. They also assume a request with req_valid low carries no obligation. The direction-dependent properties, such as forward-only-on-write and the 4 GB split, are judged only at the cycle after a valid request.

The bench sets the config registers only through the write port and drives every request field at the falling edge. It checks outputs just after the rising edge. Each sweep covers every kind, direction and completion flag against a 16 MB address grid plus the window edges, so no stimulus falls outside the documented encodings.

// File: rtl/hid_pkg.sv
package hid_pkg;
   localparam int CFG_W = 32;
   localparam int SEL_W = 4;

   typedef enum logic [1:0] {
      HID_KIND_MEM = 2'd0,
      HID_KIND_IO  = 2'd1,
      HID_KIND_CFG = 2'd2,
      HID_KIND_RSV = 2'd3
   } hid_kind_e;

   typedef enum logic [1:0] {
      HID_ACCEPT  = 2'd0,
      HID_FORWARD = 2'd1,
      HID_ABORT   = 2'd2,
      HID_DROP    = 2'd3
   } hid_dec_e;
endpackage

// File: rtl/hid_range_cmp.sv
module hid_range_cmp #(
   parameter int W = 32
) (
   input  logic [W-1:0] addr,
   input  logic [W-1:0] base,
   input  logic [W-1:0] limit,
   output logic         hit
);
   always_comb hit = (addr >= base) && (addr <= limit);
endmodule

// File: rtl/hid_aperture_cmp.sv
module hid_aperture_cmp #(
   parameter int W        = 32,
   parameter int MIN_LOG2 = 12
) (
   input  logic [W-1:0] addr,
   input  logic [W-1:0] base,
   input  logic [4:0]   size_log2,
   output logic         hit
);
   localparam int LOG_W = 5;

   if (MIN_LOG2 < 1 || MIN_LOG2 > (1 << LOG_W) - 1) begin : g_bad_min
      $error("aperture minimum exponent out of range");
   end

   logic         enabled;
   logic [W-1:0] mask;

   always_comb begin
      enabled = (int'(size_log2) >= MIN_LOG2);
      mask    = ~((W'(1) << size_log2) - W'(1));
      hit     = enabled && ((addr & mask) == (base & mask));
   end
endmodule

// File: rtl/hid_cfg_regs.sv
module hid_cfg_regs
   import hid_pkg::*;
#(
   parameter int N_WIN = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        we,
   input  logic [SEL_W-1:0]            sel,
   input  logic [CFG_W-1:0]            wdata,
   output logic [CFG_W-1:0]            tom,
   output logic [CFG_W-1:0]            smm_base,
   output logic [CFG_W-1:0]            smm_limit,
   output logic [N_WIN-1:0][CFG_W-1:0] win_base,
   output logic [N_WIN-1:0][CFG_W-1:0] win_limit,
   output logic [CFG_W-1:0]            ap_base,
   output logic [4:0]                  ap_log2,
   output logic                        vga_en
);
   localparam int SEL_TOM     = 0;
   localparam int SEL_SMM_B   = 1;
   localparam int SEL_SMM_L   = 2;
   localparam int SEL_WIN0    = 3;
   localparam int SEL_AP_BASE = SEL_WIN0 + 2 * N_WIN;
   localparam int SEL_AP_LOG2 = SEL_AP_BASE + 1;
   localparam int SEL_VGA     = SEL_AP_BASE + 2;

   if (N_WIN < 1 || SEL_VGA >= (1 << SEL_W)) begin : g_bad_nwin
      $error("window count does not fit the select field");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tom       <= '0;
         smm_base  <= '1;
         smm_limit <= '0;
         win_base  <= '1;
         win_limit <= '0;
         ap_base   <= '0;
         ap_log2   <= '0;
         vga_en    <= 1'b0;
      end else if (we) begin
         if (int'(sel) == SEL_TOM)     tom       <= wdata;
         if (int'(sel) == SEL_SMM_B)   smm_base  <= wdata;
         if (int'(sel) == SEL_SMM_L)   smm_limit <= wdata;
         if (int'(sel) == SEL_AP_BASE) ap_base   <= wdata;
         if (int'(sel) == SEL_AP_LOG2) ap_log2   <= wdata[4:0];
         if (int'(sel) == SEL_VGA)     vga_en    <= wdata[0];
         for (int i = 0; i < N_WIN; i++) begin
            if (int'(sel) == SEL_WIN0 + 2 * i)     win_base[i]  <= wdata;
            if (int'(sel) == SEL_WIN0 + 2 * i + 1) win_limit[i] <= wdata;
         end
      end
   end

   assert_tom_load_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (we && int'(sel) == SEL_TOM) |=> (tom == $past(wdata)));
   assert_tom_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(tom));
endmodule

// File: rtl/hid_classify.sv
module hid_classify
   import hid_pkg::*;
#(
   parameter int ADDR_W      = 64,
   parameter int N_WIN       = 2,
   parameter int AP_MIN_LOG2 = 12
) (
   input  logic [1:0]                  kind,
   input  logic                        write,
   input  logic                        needs_cpl,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [CFG_W-1:0]            tom,
   input  logic [CFG_W-1:0]            smm_base,
   input  logic [CFG_W-1:0]            smm_limit,
   input  logic [N_WIN-1:0][CFG_W-1:0] win_base,
   input  logic [N_WIN-1:0][CFG_W-1:0] win_limit,
   input  logic [CFG_W-1:0]            ap_base,
   input  logic [4:0]                  ap_log2,
   input  logic                        vga_en,
   output hid_dec_e                    code,
   output logic                        cpl
);
   localparam logic [CFG_W-1:0] VGA_LO = CFG_W'(32'h000A_0000);
   localparam logic [CFG_W-1:0] VGA_HI = CFG_W'(32'h000B_FFFF);

   if (ADDR_W <= CFG_W || ADDR_W > 64) begin : g_bad_aw
      $error("address width must exceed 32 and not exceed 64");
   end

   logic [CFG_W-1:0] lo;
   logic             hi_set;
   logic             smm_hit;
   logic             ap_hit;
   logic [N_WIN-1:0] win_hit;
   logic             vga_hit;
   hid_dec_e         refuse;

   assign lo     = addr[CFG_W-1:0];
   assign hi_set = |addr[ADDR_W-1:CFG_W];

   hid_range_cmp #(.W(CFG_W)) u_smm (
      .addr(lo), .base(smm_base), .limit(smm_limit), .hit(smm_hit));

   hid_aperture_cmp #(.W(CFG_W), .MIN_LOG2(AP_MIN_LOG2)) u_ap (
      .addr(lo), .base(ap_base), .size_log2(ap_log2), .hit(ap_hit));

   for (genvar g = 0; g < N_WIN; g++) begin : g_win
      hid_range_cmp #(.W(CFG_W)) u_win (
         .addr(lo), .base(win_base[g]), .limit(win_limit[g]), .hit(win_hit[g]));
   end

   hid_range_cmp #(.W(CFG_W)) u_vga (
      .addr(lo), .base(VGA_LO), .limit(VGA_HI), .hit(vga_hit));

   always_comb begin
      refuse = write ? HID_DROP : HID_ABORT;
      if (kind != HID_KIND_MEM)          code = needs_cpl ? HID_ABORT : HID_DROP;
      else if (hi_set)                   code = refuse;
      else if (smm_hit)                  code = refuse;
      else if (ap_hit)                   code = HID_ACCEPT;
      else if (|win_hit)                 code = write ? HID_FORWARD : HID_ABORT;
      else if (vga_hit && write && vga_en) code = HID_FORWARD;
      else if (lo < tom)                 code = HID_ACCEPT;
      else                               code = refuse;

      unique case (code)
         HID_ABORT: cpl = 1'b1;
         HID_DROP:  cpl = 1'b0;
         default:   cpl = needs_cpl;
      endcase
   end
endmodule

// File: rtl/hub_inbound_decoder.sv
module hub_inbound_decoder
   import hid_pkg::*;
#(
   parameter int ADDR_W      = 64,
   parameter int N_WIN       = 2,
   parameter int AP_MIN_LOG2 = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [3:0]        cfg_sel,
   input  logic [31:0]       cfg_wdata,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic              req_write,
   input  logic              req_needs_cpl,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              dec_valid,
   output logic [1:0]        dec_code,
   output logic              dec_cpl
);
   logic [CFG_W-1:0]            tom, smm_base, smm_limit, ap_base;
   logic [N_WIN-1:0][CFG_W-1:0] win_base, win_limit;
   logic [4:0]                  ap_log2;
   logic                        vga_en;
   hid_dec_e                    nxt_code;
   logic                        nxt_cpl;

   hid_cfg_regs #(.N_WIN(N_WIN)) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
      .tom(tom), .smm_base(smm_base), .smm_limit(smm_limit),
      .win_base(win_base), .win_limit(win_limit),
      .ap_base(ap_base), .ap_log2(ap_log2), .vga_en(vga_en));

   hid_classify #(.ADDR_W(ADDR_W), .N_WIN(N_WIN), .AP_MIN_LOG2(AP_MIN_LOG2)) u_cls (
      .kind(req_kind), .write(req_write), .needs_cpl(req_needs_cpl), .addr(req_addr),
      .tom(tom), .smm_base(smm_base), .smm_limit(smm_limit),
      .win_base(win_base), .win_limit(win_limit),
      .ap_base(ap_base), .ap_log2(ap_log2), .vga_en(vga_en),
      .code(nxt_code), .cpl(nxt_cpl));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid <= 1'b0;
         dec_code  <= HID_DROP;
         dec_cpl   <= 1'b0;
      end else begin
         dec_valid <= req_valid;
         if (req_valid) begin
            dec_code <= nxt_code;
            dec_cpl  <= nxt_cpl;
         end
      end
   end

   assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> dec_valid);
   assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!dec_valid && $stable(dec_code)));
   assert_nonmem_unclaimed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind != HID_KIND_MEM) |=>
         (dec_code == HID_ABORT || dec_code == HID_DROP));
   assert_high_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == HID_KIND_MEM && !req_write && |req_addr[ADDR_W-1:32])
         |=> dec_code == HID_ABORT);
   assert_high_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind == HID_KIND_MEM && req_write && |req_addr[ADDR_W-1:32])
         |=> dec_code == HID_DROP);
   assert_fwd_write_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> dec_code != HID_FORWARD);
   assert_drop_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_code == HID_DROP) |-> !dec_cpl);
   assert_abort_cpl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_valid && dec_code == HID_ABORT) |-> dec_cpl);
endmodule

// File: tb/hub_inbound_decoder_test.sv
module hub_inbound_decoder_test;
   localparam int AW = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [3:0]    cfg_sel = '0;
   logic [31:0]   cfg_wdata = '0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_kind = '0;
   logic          req_write = 1'b0;
   logic          req_needs_cpl = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          dec_valid;
   logic [1:0]    dec_code;
   logic          dec_cpl;

   int n_tests = 0;
   int n_fail  = 0;

   // bench-side copy of the register values written through the port
   logic [31:0] m_tom, m_smm_b, m_smm_l, m_ap_b, m_vga;
   logic [31:0] m_wb [2];
   logic [31:0] m_wl [2];
   int          m_ap_l;

   always #2.5 clk = ~clk;

   hub_inbound_decoder uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .req_valid(req_valid), .req_kind(req_kind), .req_write(req_write),
      .req_needs_cpl(req_needs_cpl), .req_addr(req_addr),
      .dec_valid(dec_valid), .dec_code(dec_code), .dec_cpl(dec_cpl));

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic void model(input logic [1:0] kind, input logic w, input logic c,
                                 input logic [63:0] a, output logic [1:0] code,
                                 output logic cpl, output string tag);
      logic [31:0] lo = a[31:0];
      logic [1:0]  refuse = w ? 2'd3 : 2'd2;
      logic        wh = 1'b0;
      logic        aph;
      longint      sz;
      for (int i = 0; i < 2; i++) if (lo >= m_wb[i] && lo <= m_wl[i]) wh = 1'b1;
      sz  = longint'(1) << m_ap_l;
      aph = (m_ap_l >= 12) && (longint'(lo) / sz == longint'(m_ap_b) / sz);
      if (kind != 2'd0)                         begin code = c ? 2'd2 : 2'd3; tag = "R2";  end
      else if (a[63:32] != 0)                   begin code = refuse; tag = w ? "R4" : "R3"; end
      else if (lo >= m_smm_b && lo <= m_smm_l)  begin code = refuse; tag = "R5";  end
      else if (aph)                             begin code = 2'd0;   tag = "R6";  end
      else if (wh)                              begin code = w ? 2'd1 : 2'd2; tag = "R7"; end
      else if (lo >= 32'hA0000 && lo <= 32'hBFFFF && w && m_vga[0])
                                                begin code = 2'd1;   tag = "R8";  end
      else if (lo < m_tom)                      begin code = 2'd0;   tag = "R9";  end
      else                                      begin code = refuse; tag = "R10"; end
      cpl = (code == 2'd2) ? 1'b1 : (code == 2'd3) ? 1'b0 : c;
   endfunction

   task automatic cfg_write(input int sel, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 4'(sel); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      case (sel)
         0: m_tom = d;   1: m_smm_b = d; 2: m_smm_l = d;
         3: m_wb[0] = d; 4: m_wl[0] = d; 5: m_wb[1] = d; 6: m_wl[1] = d;
         7: m_ap_b = d;  8: m_ap_l = int'(d[4:0]); 9: m_vga = {31'b0, d[0]};
         default: ;
      endcase
   endtask

   task automatic issue(input logic [1:0] kind, input logic w, input logic c,
                        input logic [63:0] a);
      logic [1:0] ec;
      logic       ep;
      string      tag;
      model(kind, w, c, a, ec, ep, tag);
      @(negedge clk);
      req_valid = 1'b1; req_kind = kind; req_write = w; req_needs_cpl = c; req_addr = a;
      @(posedge clk);
      #1;
      check({tag, " code/cpl (R11) valid (R1)"}, {4'b0, dec_valid, dec_code, dec_cpl},
            {4'b0, 1'b1, ec, ep});
   endtask

   function automatic logic [63:0] sweep_addr(input int i);
      logic [63:0] extra [12] = '{64'h9_FFFF, 64'hA_0000, 64'hB_0000, 64'hB_FFFF,
                                  64'hC_0000, 64'h030F_FFFF, 64'h0310_0000, 64'h1_0000_0000,
                                  64'h1_0000_1000, 64'h8000_0000_0000_1000,
                                  64'hFFFF_FFFF_FFFF_FFFF, 64'h0};
      if (i < 512) return (64'(i / 2) << 24) + ((i % 2) ? 64'hFF_FFFF : 64'h0);
      return extra[i - 512];
   endfunction

   task automatic sweep();
      for (int i = 0; i < 524; i++)
         for (int k = 0; k < 4; k++)
            for (int f = 0; f < 4; f++)
               issue(2'(k), f[0], f[1], sweep_addr(i));
      @(negedge clk);
      req_valid = 1'b0;
      @(posedge clk);
      #1;
      check("R1 idle", {7'b0, dec_valid}, 8'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      m_tom = 0; m_smm_b = '1; m_smm_l = 0; m_ap_b = 0; m_ap_l = 0; m_vga = 0;
      m_wb[0] = '1; m_wb[1] = '1; m_wl[0] = 0; m_wl[1] = 0;
      repeat (3) @(posedge clk);
      #1;
      check("R12 reset outputs", {5'b0, dec_valid, dec_code}, {5'b0, 1'b0, 2'd3});
      check("R12 reset cpl", {7'b0, dec_cpl}, 8'd0);
      @(negedge clk);
      rst_n = 1'b1;
      // defaults: everything unclaimed
      issue(2'd0, 1'b0, 1'b1, 64'h1000);
      issue(2'd0, 1'b1, 1'b0, 64'h1000);

      // phase 1: full map, VGA forwarding on
      cfg_write(0, 32'h0400_0000);
      cfg_write(1, 32'h0300_0000); cfg_write(2, 32'h030F_FFFF);
      cfg_write(3, 32'h8000_0000); cfg_write(4, 32'h80FF_FFFF);
      cfg_write(5, 32'hC000_0000); cfg_write(6, 32'hC0FF_FFFF);
      cfg_write(7, 32'hE012_3000); cfg_write(8, 32'd24);
      cfg_write(9, 32'd1);
      cfg_write(12, 32'h0);          // unused select must change nothing
      sweep();

      // phase 2: aperture over window 0 (priority), VGA off
      cfg_write(7, 32'h8000_0000); cfg_write(9, 32'd0);
      sweep();

      // phase 3: aperture exponent below the minimum disables it
      cfg_write(8, 32'd5);
      sweep();

      // R12 write timing: request in the write cycle sees the old top-of-memory
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 4'd0; cfg_wdata = 32'h0;
      req_valid = 1'b1; req_kind = 2'd0; req_write = 1'b0; req_needs_cpl = 1'b1;
      req_addr = 64'h1000;
      @(posedge clk);
      #1;
      check("R12 old value in write cycle", {6'b0, dec_code}, 8'd0);
      @(negedge clk);
      cfg_we = 1'b0;
      m_tom = 0;
      @(posedge clk);
      #1;
      check("R12 new value after write", {6'b0, dec_code}, 8'd2);
      @(negedge clk);
      req_valid = 1'b0;

      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule